// File: doc/BRIEF.md
# Clock-Buffer Configuration Target on SMBus

This block is the serial configuration target of a multi-output clock distribution device. A host reaches a small bank of nine byte-wide registers over a two-wire SMBus link. The registers hold per-output enables, a software override for the loop-filter mode, a programmable read-length value, and fixed identification bytes. Both bus lines are oversampled by the block's own clock. The data line is driven through an open-drain style pull-low output.

Accesses use a running index. A write names a start index, then a byte count, then that many data bytes, and each data byte goes to the next register. A read first sets the index with a short write phase. The host then issues a repeated START with the read bit, and the device returns its read-length register followed by register contents from the index onward. The device address is chosen from nine values by two three-level strap inputs. Those straps, the strapped PLL mode and the frequency select are captured once, on the first clock after reset where power-good is high.

Top module: `clkcfg_smbus_target`

## Requirements
- R1: The 7-bit device address comes from the strap pair (A1,A0). Each strap is coded 2'b00 low, 2'b01 mid, 2'b10 high, and 2'b11 counts as high. The nine pairs select these addresses: low/low 0x6C, low/mid 0x6D, low/high 0x6F, mid/low 0x61, mid/mid 0x62, mid/high 0x63, high/low 0x65, high/mid 0x66, high/high 0x67. Only that address is acknowledged. Any other address is not acknowledged, and the device then leaves SDA alone until the next START.
- R2: The straps, the 2-bit PLL-mode strap and the frequency-select strap are captured on the first clock after reset with pwr_good high. Later changes on them are ignored until reset. Before the capture, the device acknowledges nothing.
- R3: Reset contents are as follows. Index 0 reads {mode[1:0], 2'b00, 1'b0, 2'b11, fsel}. Index 1 reads 0xFF and index 2 reads 0x0F. Indices 3, 4 and 7 read 0x00. Index 5 reads {REV_ID, 4'b0001}, index 6 reads DEVICE_ID (0xE6 by default), and index 8 reads 0x08.
- R4: A write is START, address with R/W=0, index N, count X, then data bytes. The device acknowledges each byte and stores the data bytes at N, N+1, and onward, in order.
- R5: Data bytes after the first X are not acknowledged and not stored. With X=0, the first data byte is not acknowledged.
- R6: After a repeated START with the address and R/W=1, the device first sends the full contents of index 8. It then sends registers starting at index N, moving to the next one each time the host acknowledges.
- R7: The index advances after every data byte written or read, but not after the count byte. After index 8, or after any index above 8, it returns to 0. Indices above 8 read 0x00 and ignore writes.
- R8: These fields ignore writes, but the write is still acknowledged: index 0 bits 7:4 and bit 0, indices 3 to 7 in full, index 2 bits 7:4, and index 8 bits 7:5. The writable fields are index 0 bits 3:1, index 1, index 2 bits 3:0, and index 8 bits 4:0.
- R9: out_enable[7:0] equals index 1 and out_enable[11:8] equals index 2 bits 3:0. mode_sw_en equals index 0 bit 3, and mode_sw_sel equals index 0 bits 2:1.
- R10: A NACK from the host after a read byte ends the transfer. The device releases SDA and drives nothing until the next START.
- R11: The device changes sda_pull_low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Power-good; its first high captures the straps |
| addr_sel1 | input | 2 | Three-level address strap A1 |
| addr_sel0 | input | 2 | Three-level address strap A0 |
| pll_mode_strap | input | 2 | Strapped PLL mode, shown at index 0 bits 7:6 |
| freq_sel_strap | input | 1 | Strapped frequency select, shown at index 0 bit 0 |
| scl_in | input | 1 | SMBus clock line |
| sda_in | input | 1 | SMBus data line as seen on the bus |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| out_enable | output | 12 | Per-output enables |
| mode_sw_en | output | 1 | Software mode override enable |
| mode_sw_sel | output | 2 | Software-selected PLL mode |

## Verification
Some rules hold on every cycle and are checked there by assertions. The device never drives SDA while idle or before the straps are captured. SDA changes only while SCL is low. The captured address and straps never move after capture. The index wraps from 8 to 0 during reads. A write to an enable register reaches out_enable on the next cycle. Other behaviours need whole transactions, and only the bench scenarios can show them. These are the full nine-way address decode together with rejection of the other eight addresses, the byte-count cut-off, the protection of read-only fields across full-bank writes, the read-length byte that leads each read, and the silence after a host NACK.

// File: rtl/clkcfg_pkg.sv
// Shared constants, state types and the strap-to-address decode for the
// configuration target. Assumes three-level straps arrive pre-digitised.
package clkcfg_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int IDX_W    = 8;
    localparam int REG_AW   = 4;
    localparam int REG_LAST = 8;
    localparam int NUM_OUT  = 12;
    localparam int EN_LO_W  = 8;
    localparam int EN_HI_W  = NUM_OUT - EN_LO_W;
    localparam int BCNT_W   = 5;

    localparam logic [1:0] LVL_LOW = 2'b00;
    localparam logic [1:0] LVL_MID = 2'b01;

    typedef enum logic [2:0] {PS_IDLE, PS_RX, PS_ACK, PS_TX, PS_HACK} proto_st_e;
    typedef enum logic [1:0] {RK_ADDR, RK_INDEX, RK_COUNT, RK_DATA} rx_kind_e;

    // Low, mid and high become the digits 0, 1 and 2; code 2'b11 counts as high.
    function automatic logic [1:0] lvl_digit(input logic [1:0] lvl);
        return (lvl == LVL_LOW) ? 2'd0 : (lvl == LVL_MID) ? 2'd1 : 2'd2;
    endfunction

    // Base-3 strap pair to 7-bit bus address.
    function automatic logic [ADDR_W-1:0] strap_addr(input logic [1:0] a1, input logic [1:0] a0);
        logic [3:0] sel;
        sel = 4'(lvl_digit(a1)) * 4'd3 + 4'(lvl_digit(a0));
        case (sel)
            4'd0:    return 7'h6C;
            4'd1:    return 7'h6D;
            4'd2:    return 7'h6F;
            4'd3:    return 7'h61;
            4'd4:    return 7'h62;
            4'd5:    return 7'h63;
            4'd6:    return 7'h65;
            4'd7:    return 7'h66;
            default: return 7'h67;
        endcase
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
// Two-flop synchroniser for SCL and SDA with edge and START/STOP detection.
// Assumes clk is at least ~8x faster than the bus clock.
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_q;
    logic       sda_q;

    // Sync both lines and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_in};
            sda_ff <= {sda_ff[0], sda_in};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    assign scl_s     = scl_ff[1];
    assign sda_s     = sda_ff[1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_strap_latch.sv
// Captures address straps and mode/frequency straps once, on the first
// clock with pwr_good high after reset; holds them until the next reset.
module cfg_strap_latch
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic [1:0]        addr_sel1,
    input  logic [1:0]        addr_sel0,
    input  logic [1:0]        mode_strap,
    input  logic              fsel_strap,
    output logic              locked,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [1:0]        mode_lat,
    output logic              fsel_lat
);
    // One-shot capture of the strap set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            dev_addr <= '0;
            mode_lat <= '0;
            fsel_lat <= 1'b0;
        end else if (pwr_good && !locked) begin
            locked   <= 1'b1;
            dev_addr <= strap_addr(addr_sel1, addr_sel0);
            mode_lat <= mode_strap;
            fsel_lat <= fsel_strap;
        end
    end

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked && $stable(dev_addr) && $stable(mode_lat) && $stable(fsel_lat));
endmodule

// File: rtl/clkcfg_regbank.sv
// Nine-entry configuration bank: writable fields, latched read-only fields,
// fixed identity bytes, and the parallel control outputs they drive.
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter logic [3:0]        REV_ID    = 4'h0,
    parameter logic [3:0]        VENDOR_ID = 4'h1,
    parameter logic [BYTE_W-1:0] DEVICE_ID = 8'hE6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [REG_AW-1:0]  addr,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [1:0]         mode_lat,
    input  logic               fsel_lat,
    output logic [BYTE_W-1:0]  rdata,
    output logic [BYTE_W-1:0]  cnt_byte,
    output logic [NUM_OUT-1:0] out_en,
    output logic               sw_en,
    output logic [1:0]         sw_sel
);
    logic [EN_LO_W-1:0] en_lo_q;
    logic [EN_HI_W-1:0] en_hi_q;
    logic [BCNT_W-1:0]  bcnt_q;

    // Writable fields only; other bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en   <= 1'b0;
            sw_sel  <= 2'b11;
            en_lo_q <= '1;
            en_hi_q <= '1;
            bcnt_q  <= BCNT_W'(8);
        end else if (we) begin
            case (addr)
                4'd0: begin
                    sw_en  <= wdata[3];
                    sw_sel <= wdata[2:1];
                end
                4'd1:    en_lo_q <= wdata[EN_LO_W-1:0];
                4'd2:    en_hi_q <= wdata[EN_HI_W-1:0];
                4'd8:    bcnt_q  <= wdata[BCNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Read mux assembling each index view.
    always_comb begin
        case (addr)
            4'd0:    rdata = {mode_lat, 2'b00, sw_en, sw_sel, fsel_lat};
            4'd1:    rdata = BYTE_W'(en_lo_q);
            4'd2:    rdata = BYTE_W'(en_hi_q);
            4'd5:    rdata = {REV_ID, VENDOR_ID};
            4'd6:    rdata = DEVICE_ID;
            4'd8:    rdata = BYTE_W'(bcnt_q);
            default: rdata = '0;
        endcase
    end

    assign cnt_byte = BYTE_W'(bcnt_q);
    assign out_en   = {en_hi_q, en_lo_q};

    // R9
    en_lo_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 4'd1) |=> (out_en[EN_LO_W-1:0] == $past(wdata[EN_LO_W-1:0])));
    // R9
    en_hi_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 4'd2) |=> (out_en[NUM_OUT-1:EN_LO_W] == $past(wdata[EN_HI_W-1:0])));
endmodule

// File: rtl/smb_proto.sv
// Bus protocol engine: address match, index/count/data phases, read
// streaming with a leading count byte. Assumes synchronised line inputs.
module smb_proto
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic [BYTE_W-1:0] cnt_byte,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              sda_low
);
    proto_st_e         st;
    rx_kind_e          kind;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx_sh;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] wr_left;
    logic              is_read;
    logic              hack_ok;
    logic              idx_hit;
    logic [IDX_W-1:0]  idx_adv;
    logic [BYTE_W-1:0] rd_byte;

    assign idx_hit   = (idx <= IDX_W'(REG_LAST));
    assign idx_adv   = idx_hit && (idx != IDX_W'(REG_LAST)) ? idx + 1'b1 : '0;
    assign rd_byte   = idx_hit ? reg_rdata : '0;
    assign reg_addr  = idx[REG_AW-1:0];
    assign reg_wdata = shreg;
    assign reg_we    = (st == PS_RX) && (kind == RK_DATA) && scl_fall &&
                       (bitcnt == 4'd8) && (wr_left != '0) && idx_hit;

    // Transaction sequencing, shifting and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= PS_IDLE;  kind <= RK_ADDR;  bitcnt <= '0;
            shreg <= '0;  tx_sh <= '0;  idx <= '0;  wr_left <= '0;
            is_read <= 1'b0;  hack_ok <= 1'b0;  sda_low <= 1'b0;
        end else if (start_det) begin
            st <= PS_RX;  kind <= RK_ADDR;  bitcnt <= '0;  sda_low <= 1'b0;
        end else if (stop_det) begin
            st <= PS_IDLE;  sda_low <= 1'b0;
        end else begin
            case (st)
                PS_RX: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        st <= PS_ACK;  sda_low <= 1'b1;
                        case (kind)
                            RK_ADDR: begin
                                if (!addr_valid || shreg[BYTE_W-1:1] != dev_addr) begin
                                    st <= PS_IDLE;  sda_low <= 1'b0;
                                end else begin
                                    is_read <= shreg[0];  kind <= RK_INDEX;
                                end
                            end
                            RK_INDEX: begin idx <= shreg;  kind <= RK_COUNT; end
                            RK_COUNT: begin wr_left <= shreg;  kind <= RK_DATA; end
                            default: begin
                                if (wr_left == '0) begin
                                    st <= PS_IDLE;  sda_low <= 1'b0;
                                end else begin
                                    wr_left <= wr_left - 1'b1;  idx <= idx_adv;
                                end
                            end
                        endcase
                    end
                end
                PS_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (is_read) begin
                            st <= PS_TX;  tx_sh <= cnt_byte;  sda_low <= ~cnt_byte[BYTE_W-1];
                        end else begin
                            st <= PS_RX;  sda_low <= 1'b0;
                        end
                    end
                end
                PS_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            st <= PS_HACK;  sda_low <= 1'b0;
                        end else begin
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_low <= ~tx_sh[BYTE_W-2];
                            bitcnt  <= bitcnt + 1'b1;
                        end
                    end
                end
                PS_HACK: begin
                    if (scl_rise) begin
                        hack_ok <= ~sda_s;
                    end else if (scl_fall) begin
                        if (!hack_ok) begin
                            st <= PS_IDLE;
                        end else begin
                            st <= PS_TX;  bitcnt <= '0;  tx_sh <= rd_byte;
                            sda_low <= ~rd_byte[BYTE_W-1];  idx <= idx_adv;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_IDLE) |-> !sda_low);
    // R11
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !scl_s);
    // R2
    unlocked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> !sda_low);
    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_HACK && scl_fall && !scl_rise && hack_ok && !start_det && !stop_det &&
         idx == IDX_W'(REG_LAST)) |=> (idx == '0));
endmodule

// File: rtl/clkcfg_smbus_target.sv
// Top of the configuration target: line sync, strap capture, protocol
// engine and register bank. Assumes external pull-up on SDA.
module clkcfg_smbus_target
    import clkcfg_pkg::*;
#(
    parameter logic [3:0]        REV_ID    = 4'h0,
    parameter logic [3:0]        VENDOR_ID = 4'h1,
    parameter logic [BYTE_W-1:0] DEVICE_ID = 8'hE6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good,
    input  logic [1:0]         addr_sel1,
    input  logic [1:0]         addr_sel0,
    input  logic [1:0]         pll_mode_strap,
    input  logic               freq_sel_strap,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull_low,
    output logic [NUM_OUT-1:0] out_enable,
    output logic               mode_sw_en,
    output logic [1:0]         mode_sw_sel
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic locked, fsel_lat;
    logic [1:0] mode_lat;
    logic [ADDR_W-1:0] dev_addr;
    logic reg_we;
    logic [REG_AW-1:0] reg_addr;
    logic [BYTE_W-1:0] reg_wdata, reg_rdata, cnt_byte;

    smb_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfg_strap_latch u_strap (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .addr_sel1(addr_sel1), .addr_sel0(addr_sel0),
        .mode_strap(pll_mode_strap), .fsel_strap(freq_sel_strap),
        .locked(locked), .dev_addr(dev_addr), .mode_lat(mode_lat), .fsel_lat(fsel_lat)
    );

    smb_proto u_proto (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_valid(locked), .dev_addr(dev_addr), .reg_rdata(reg_rdata), .cnt_byte(cnt_byte),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sda_low(sda_pull_low)
    );

    clkcfg_regbank #(.REV_ID(REV_ID), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .mode_lat(mode_lat), .fsel_lat(fsel_lat), .rdata(reg_rdata), .cnt_byte(cnt_byte),
        .out_en(out_enable), .sw_en(mode_sw_en), .sw_sel(mode_sw_sel)
    );
endmodule

// File: tb/clkcfg_smbus_target_tb_top.sv
// Bench: bit-level bus host, address sweep over all straps, register model.
module clkcfg_smbus_target_tb_top;
    localparam int Q = 5;
    localparam logic [3:0] TB_REV = 4'h3;

    logic clk = 1'b0;
    logic rst_n, pwr_good, freq_sel_strap, scl, sda_h, sda_bus, sda_pull_low;
    logic [1:0] addr_sel1, addr_sel0, pll_mode_strap, mode_sw_sel;
    logic [11:0] out_enable;
    logic mode_sw_en;

    int tests = 0;
    int fails = 0;
    int sda_viol = 0;
    logic prev_drv = 1'b0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    logic       wack [16];
    logic       hdr_ok;
    logic [7:0] exp_reg [9];
    logic [7:0] addr8 [9];

    always #5 clk = ~clk;
    assign sda_bus = sda_h & ~sda_pull_low;

    clkcfg_smbus_target #(.REV_ID(TB_REV)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .addr_sel1(addr_sel1), .addr_sel0(addr_sel0),
        .pll_mode_strap(pll_mode_strap), .freq_sel_strap(freq_sel_strap),
        .scl_in(scl), .sda_in(sda_bus), .sda_pull_low(sda_pull_low),
        .out_enable(out_enable), .mode_sw_en(mode_sw_en), .mode_sw_sel(mode_sw_sel)
    );

    // R11 monitor: the pull-low output must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && scl && (sda_pull_low !== prev_drv)) sda_viol++;
        prev_drv <= sda_pull_low;
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wc(Q); scl = 1'b1; wc(Q); sda_h = 1'b0; wc(Q); scl = 1'b0; wc(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wc(Q); scl = 1'b1; wc(Q); sda_h = 1'b1; wc(Q);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_h = b; wc(Q); scl = 1'b1; wc(Q); s = sda_bus; wc(Q); scl = 1'b0; wc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    task automatic probe(input logic [6:0] a7, output logic ack);
        bus_start();
        send_byte({a7, 1'b0}, ack);
        bus_stop();
    endtask

    task automatic wr_block(input logic [6:0] a7, input logic [7:0] idx, input logic [7:0] cnt, input int n);
        logic a0, a1, a2;
        bus_start();
        send_byte({a7, 1'b0}, a0);
        send_byte(idx, a1);
        send_byte(cnt, a2);
        for (int k = 0; k < n; k++) send_byte(wbuf[k], wack[k]);
        bus_stop();
        hdr_ok = a0 & a1 & a2;
    endtask

    task automatic rd_block(input logic [6:0] a7, input logic [7:0] idx, input int n);
        logic a0, a1, a2;
        bus_start();
        send_byte({a7, 1'b0}, a0);
        send_byte(idx, a1);
        bus_start();
        send_byte({a7, 1'b1}, a2);
        recv_byte(1'b1, rbuf[0]);
        for (int k = 1; k <= n; k++) recv_byte(k < n, rbuf[k]);
        bus_stop();
        hdr_ok = a0 & a1 & a2;
    endtask

    function automatic logic [7:0] wmask(input int r);
        case (r)
            0: return 8'h0E;
            1: return 8'hFF;
            2: return 8'h0F;
            8: return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input int idx, input int cnt, input int n);
        int p;
        p = idx;
        for (int k = 0; k < n && k < cnt; k++) begin
            if (p <= 8) exp_reg[p] = (exp_reg[p] & ~wmask(p)) | (wbuf[k] & wmask(p));
            p = (p >= 8) ? 0 : p + 1;
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, "out_enable", 32'(out_enable), 32'({exp_reg[2][3:0], exp_reg[1]}));
        check(req, "mode_sw_en", 32'(mode_sw_en), 32'(exp_reg[0][3]));
        check(req, "mode_sw_sel", 32'(mode_sw_sel), 32'(exp_reg[0][2:1]));
    endtask

    task automatic verify_all(input logic [6:0] a7, input string req);
        rd_block(a7, 8'd0, 9);
        check("R6", "read header acks", 32'(hdr_ok), 32'd1);
        check("R6", "count byte", 32'(rbuf[0]), 32'(exp_reg[8]));
        for (int k = 0; k < 9; k++) check(req, $sformatf("index %0d", k), 32'(rbuf[k + 1]), 32'(exp_reg[k]));
        check_outputs("R9");
    endtask

    task automatic power_up(input logic [1:0] s1, input logic [1:0] s0);
        rst_n = 1'b0; pwr_good = 1'b0; addr_sel1 = s1; addr_sel0 = s0;
        wc(3); rst_n = 1'b1; wc(2); pwr_good = 1'b1; wc(2);
    endtask

    initial begin
        logic ack;
        logic [6:0] dev;
        scl = 1'b1; sda_h = 1'b1; rst_n = 1'b0; pwr_good = 1'b0;
        addr_sel1 = 2'b00; addr_sel0 = 2'b00; pll_mode_strap = 2'b10; freq_sel_strap = 1'b1;
        addr8 = '{8'hD8, 8'hDA, 8'hDE, 8'hC2, 8'hC4, 8'hC6, 8'hCA, 8'hCC, 8'hCE};
        wc(4); rst_n = 1'b1; wc(3);

        // R3/R9 reset values at the ports
        check("R3", "sda idle", 32'(sda_pull_low), 32'd0);
        check("R9", "reset out_enable", 32'(out_enable), 32'hFFF);
        check("R9", "reset mode_sw_en", 32'(mode_sw_en), 32'd0);
        check("R9", "reset mode_sw_sel", 32'(mode_sw_sel), 32'd3);

        // R2: no answer before power-good
        probe(7'h6C, ack);
        check("R2", "ack before pwr_good", 32'(ack), 32'd0);

        // R1 sweep of all nine strap pairs, each probed with all nine addresses
        for (int a1 = 0; a1 < 3; a1++) begin
            for (int a0 = 0; a0 < 3; a0++) begin
                power_up(2'(a1), 2'(a0));
                for (int j = 0; j < 9; j++) begin
                    probe(addr8[j][7:1], ack);
                    check("R1", $sformatf("straps %0d/%0d addr %0h", a1, a0, addr8[j]),
                          32'(ack), 32'(j == a1 * 3 + a0));
                end
                addr_sel1 = 2'((a1 + 1) % 3);
                wc(2);
                probe(addr8[a1 * 3 + a0][7:1], ack);
                check("R2", "address held after strap change", 32'(ack), 32'd1);
            end
        end

        // Final configuration: high/high with code 2'b11 on A1 -> 0x67
        pll_mode_strap = 2'b10; freq_sel_strap = 1'b1;
        power_up(2'b11, 2'b10);
        dev = 7'h67;
        exp_reg = '{8'h87, 8'hFF, 8'h0F, 8'h00, 8'h00, {TB_REV, 4'h1}, 8'hE6, 8'h00, 8'h08};
        pll_mode_strap = 2'b01; freq_sel_strap = 1'b0;
        pwr_good = 1'b0; wc(3); pwr_good = 1'b1; wc(3);
        verify_all(dev, "R3");

        // R4/R8 full-bank writes with four patterns, read-back against the model
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 9; k++)
                wbuf[k] = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : (p == 2) ? 8'(8'hA5 ^ (k * 8'h11)) : 8'(8'h5A + k * 17);
            wr_block(dev, 8'd0, 8'd9, 9);
            check("R4", "write header acks", 32'(hdr_ok), 32'd1);
            for (int k = 0; k < 9; k++) check("R4", $sformatf("data ack %0d", k), 32'(wack[k]), 32'd1);
            model_write(0, 9, 9);
            verify_all(dev, "R8");
        end

        // R9 walking ones over the output enables
        for (int b = 0; b < 12; b++) begin
            wbuf[0] = (b < 8) ? 8'(1 << b) : 8'h00;
            wbuf[1] = (b < 8) ? 8'h00 : 8'(1 << (b - 8));
            wr_block(dev, 8'd1, 8'd2, 2);
            model_write(1, 2, 2);
            check("R9", $sformatf("walking enable %0d", b), 32'(out_enable), 32'(12'(1) << b));
        end

        // R7 write wrap from index 8 to 0
        wbuf[0] = 8'h08; wbuf[1] = 8'h5A; wbuf[2] = 8'h3C;
        wr_block(dev, 8'd8, 8'd3, 3);
        model_write(8, 3, 3);
        check("R7", "wrapped reg0", 32'(exp_reg[0]), 32'h8B);
        check_outputs("R7");
        // R7 read wrap from index 7
        rd_block(dev, 8'd7, 4);
        check("R7", "read idx7", 32'(rbuf[1]), 32'h00);
        check("R7", "read idx8", 32'(rbuf[2]), 32'h08);
        check("R7", "read wrap idx0", 32'(rbuf[3]), 32'h8B);
        check("R7", "read wrap idx1", 32'(rbuf[4]), 32'h3C);
        // R7 out-of-range index: ignored, then wraps to 0
        wbuf[0] = 8'h55; wbuf[1] = 8'h00;
        wr_block(dev, 8'd12, 8'd2, 2);
        check("R7", "out-of-range write ack", 32'(wack[0]), 32'd1);
        model_write(12, 2, 2);
        rd_block(dev, 8'd12, 2);
        check("R7", "out-of-range read", 32'(rbuf[1]), 32'h00);
        check("R7", "after out-of-range reg0", 32'(rbuf[2]), 32'h81);

        // R5 byte count limits
        wbuf[0] = 8'h81; wbuf[1] = 8'h77;
        wr_block(dev, 8'd1, 8'd1, 2);
        check("R5", "first byte ack", 32'(wack[0]), 32'd1);
        check("R5", "extra byte nack", 32'(wack[1]), 32'd0);
        model_write(1, 1, 2);
        check_outputs("R5");
        wbuf[0] = 8'h00;
        wr_block(dev, 8'd2, 8'd0, 1);
        check("R5", "count zero nack", 32'(wack[0]), 32'd0);
        check_outputs("R5");

        // R10: host NACK ends the read
        bus_start();
        send_byte({dev, 1'b0}, ack);
        send_byte(8'd6, ack);
        bus_start();
        send_byte({dev, 1'b1}, ack);
        recv_byte(1'b1, rbuf[0]);
        recv_byte(1'b0, rbuf[1]);
        check("R6", "read idx6 after count", 32'(rbuf[1]), 32'hE6);
        clock_bit(1'b1, ack);
        check("R10", "bus after host nack", 32'(ack), 32'd1);
        check("R10", "pull after host nack", 32'(sda_pull_low), 32'd0);
        bus_stop();
        verify_all(dev, "R10");

        check("R11", "SDA changes while SCL high", 32'(sda_viol), 32'd0);
        finish_run();
    end
endmodule